// File: doc/BRIEF.md
# ADC Result Magnitude Monitor and Accumulator

This block sits after the decimation filter of a sigma-delta converter. It receives signed conversion results, one per cycle in which `res_valid_i` is high, and applies up to two functions to each result. The first takes the sign-free magnitude of the result and compares it with a programmed level. Depending on the comparator mode, it either raises a one-cycle interrupt pulse or counts results above or below that level. The count stops at a programmed limit and raises a flag there.

The second function folds each result into a 32-bit running sum, by addition or by subtraction. Software reads the sum directly at `acc_o`. A status output stays high for as long as the sum, taken as signed, is greater than a separate signed level.

Four write-only registers, selected by a 2-bit address, hold the configuration. A write to the mode register restarts both the event count and the sum.

Top module: `adc_thresh_mon`

## Requirements
- R1: After reset, `acc_o`, `evt_cnt_o`, `thr_irq_o`, `cnt_irq_o` and `acc_exceed_o` are all zero, and both mode fields are 00 (off).
- R2: With comparator mode 01, a valid result whose magnitude is strictly greater than the magnitude level drives `thr_irq_o` high for exactly the one cycle after the edge that takes the result. Equal magnitude, or any other comparator mode, leaves `thr_irq_o` low.
- R3: The magnitude of the most negative input code is 2^(DATA_W-1)-1. With the level at 2^(DATA_W-1)-2, that input fires R2. With the level at 2^(DATA_W-1)-1, it does not.
- R4: Comparator mode 10 counts valid results whose magnitude is above the level. Mode 11 counts valid results whose magnitude is below the level. A magnitude equal to the level is never counted. The count is visible on `evt_cnt_o` after the edge.
- R5: The count stops incrementing once it is at least the limit. `cnt_irq_o` is high while the comparator mode is 10 or 11 and the count is at least the limit.
- R6: Accumulator mode 01 adds each sign-extended valid result to the sum, and mode 10 subtracts it. Both wrap modulo 2^32.
- R7: Accumulator mode 11 forces the sum to zero on every cycle. Mode 00 holds the sum, and so does a cycle without a valid result.
- R8: `acc_exceed_o` is high exactly while the signed sum is greater than the signed accumulator level, and it follows the current sum.
- R9: A write to the mode register clears the count and the sum at that edge. A result that arrives in the same cycle is neither counted nor summed. All new register values take effect from the next cycle.
- R10: The register map is as follows. Address 0 is the mode register, with the comparator mode in bits [1:0] and the accumulator mode in bits [3:2]. Address 1 is the magnitude level in bits [DATA_W-1:0]. Address 2 is the count limit in bits [CNT_W-1:0]. Address 3 is the signed 32-bit accumulator level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | 32 | Register write data |
| res_valid_i | input | 1 | Conversion result valid |
| res_data_i | input | DATA_W | Signed conversion result |
| thr_irq_o | output | 1 | Magnitude-above-level pulse |
| cnt_irq_o | output | 1 | Event count reached limit |
| acc_exceed_o | output | 1 | Sum above accumulator level |
| acc_o | output | 32 | Running sum |
| evt_cnt_o | output | CNT_W | Threshold event count |

## Verification
A write to the mode register and a valid result can land in the same cycle. In that case the restart of the count and the sum must win, and the result must be dropped. The bench forces this collision several times, both in directed cases and through random writes placed during result streams. Each time, it checks that `evt_cnt_o` and `acc_o` read zero at the next sample, and that the new modes apply only to the results that follow.

// File: rtl/adc_mon_pkg.sv
package adc_mon_pkg;
  typedef enum logic [1:0] {
    CMP_OFF    = 2'b00,
    CMP_IRQ    = 2'b01,
    CMP_CNT_HI = 2'b10,
    CMP_CNT_LO = 2'b11
  } cmp_mode_e;

  typedef enum logic [1:0] {
    ACC_OFF  = 2'b00,
    ACC_ADD  = 2'b01,
    ACC_SUB  = 2'b10,
    ACC_ZERO = 2'b11
  } acc_mode_e;

  typedef struct packed {
    acc_mode_e acc;
    cmp_mode_e cmp;
  } mode_t;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_MTH  = 2'd1;
  localparam logic [1:0] ADDR_LIM  = 2'd2;
  localparam logic [1:0] ADDR_ATH  = 2'd3;
endpackage

// File: rtl/adc_mon_regs.sv
module adc_mon_regs
  import adc_mon_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 16,
  parameter int ACC_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [ACC_W-1:0]  wr_data_i,
  output mode_t             mode_o,
  output logic [DATA_W-1:0] mag_thr_o,
  output logic [CNT_W-1:0]  cnt_lim_o,
  output logic [ACC_W-1:0]  acc_thr_o,
  output logic              mode_wr_o
);
  localparam int MODE_W = $bits(mode_t);

  mode_t             mode_q;
  logic [DATA_W-1:0] mag_thr_q;
  logic [CNT_W-1:0]  cnt_lim_q;
  logic [ACC_W-1:0]  acc_thr_q;

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= '{acc: ACC_OFF, cmp: CMP_OFF};
      mag_thr_q <= '0;
      cnt_lim_q <= '0;
      acc_thr_q <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_MODE: mode_q    <= mode_t'(wr_data_i[MODE_W-1:0]);
        ADDR_MTH:  mag_thr_q <= wr_data_i[DATA_W-1:0];
        ADDR_LIM:  cnt_lim_q <= wr_data_i[CNT_W-1:0];
        default:   acc_thr_q <= wr_data_i;
      endcase
    end
  end

  assign mode_o    = mode_q;
  assign mag_thr_o = mag_thr_q;
  assign cnt_lim_o = cnt_lim_q;
  assign acc_thr_o = acc_thr_q;
  assign mode_wr_o = wr_en_i && (wr_addr_i == ADDR_MODE);
endmodule

// File: rtl/adc_mon_mag.sv
module adc_mon_mag #(
  parameter int DATA_W = 24
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] thr_i,
  output logic [DATA_W-1:0] mag_o,
  output logic              above_o,
  output logic              below_o
);
  localparam logic [DATA_W-1:0] MIN_CODE = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MAX_MAG  = {1'b0, {(DATA_W-1){1'b1}}};

  always_comb begin
    if (data_i == MIN_CODE)      mag_o = MAX_MAG;   // saturate, no overflow
    else if (data_i[DATA_W-1])   mag_o = ~data_i + 1'b1;
    else                         mag_o = data_i;
  end

  assign above_o = mag_o > thr_i;
  assign below_o = mag_o < thr_i;
endmodule

// File: rtl/adc_mon_cnt.sv
module adc_mon_cnt
  import adc_mon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  cmp_mode_e        mode_i,
  input  logic             valid_i,
  input  logic             above_i,
  input  logic             below_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             counting, hit, full;

  assign counting = (mode_i == CMP_CNT_HI) || (mode_i == CMP_CNT_LO);
  assign hit      = (mode_i == CMP_CNT_HI) ? above_i :
                    (mode_i == CMP_CNT_LO) ? below_i : 1'b0;
  assign full     = cnt_q >= lim_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (valid_i && hit && !full)  cnt_q <= cnt_q + ONE;
  end

  assign cnt_o = cnt_q;
  assign irq_o = counting && full;

  a_r5_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !clr_i) |=> $stable(cnt_q));
  a_r4_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + ONE));
  a_r9_cnt_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/adc_mon_acc.sv
module adc_mon_acc
  import adc_mon_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ACC_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  acc_mode_e         mode_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ACC_W-1:0]  thr_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic              exceed_o
);
  logic [ACC_W-1:0] ext, acc_q;

  generate
    if (ACC_W > DATA_W) begin : g_sext
      assign ext = {{(ACC_W-DATA_W){data_i[DATA_W-1]}}, data_i};
    end else begin : g_trunc
      assign ext = data_i[ACC_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else begin
      unique case (mode_i)
        ACC_ADD:  if (valid_i) acc_q <= acc_q + ext;
        ACC_SUB:  if (valid_i) acc_q <= acc_q - ext;
        ACC_ZERO: acc_q <= '0;
        default:  ;
      endcase
    end
  end

  assign acc_o    = acc_q;
  assign exceed_o = $signed(acc_q) > $signed(thr_i);

  a_r9_acc_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_q == '0);
  a_r7_acc_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == ACC_ZERO) |=> acc_q == '0);
  a_r7_acc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && (mode_i == ACC_OFF || (!valid_i && mode_i != ACC_ZERO)))
      |=> $stable(acc_q));
endmodule

// File: rtl/adc_thresh_mon.sv
module adc_thresh_mon
  import adc_mon_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 16,
  parameter int ACC_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [ACC_W-1:0]  wr_data_i,
  input  logic              res_valid_i,
  input  logic [DATA_W-1:0] res_data_i,
  output logic              thr_irq_o,
  output logic              cnt_irq_o,
  output logic              acc_exceed_o,
  output logic [ACC_W-1:0]  acc_o,
  output logic [CNT_W-1:0]  evt_cnt_o
);
  mode_t             mode;
  logic [DATA_W-1:0] mag_thr, mag;
  logic [CNT_W-1:0]  cnt_lim;
  logic [ACC_W-1:0]  acc_thr;
  logic              mode_wr, above, below, thr_irq_q;

  adc_mon_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .mode_o(mode), .mag_thr_o(mag_thr), .cnt_lim_o(cnt_lim),
    .acc_thr_o(acc_thr), .mode_wr_o(mode_wr)
  );

  adc_mon_mag #(.DATA_W(DATA_W)) u_mag (
    .data_i(res_data_i), .thr_i(mag_thr), .mag_o(mag),
    .above_o(above), .below_o(below)
  );

  adc_mon_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .clr_i(mode_wr), .mode_i(mode.cmp),
    .valid_i(res_valid_i), .above_i(above), .below_i(below),
    .lim_i(cnt_lim), .cnt_o(evt_cnt_o), .irq_o(cnt_irq_o)
  );

  adc_mon_acc #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
    .clk_i, .rst_ni, .clr_i(mode_wr), .mode_i(mode.acc),
    .valid_i(res_valid_i), .data_i(res_data_i), .thr_i(acc_thr),
    .acc_o(acc_o), .exceed_o(acc_exceed_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) thr_irq_q <= 1'b0;
    else         thr_irq_q <= res_valid_i && (mode.cmp == CMP_IRQ) && above;
  end
  assign thr_irq_o = thr_irq_q;

  a_r2_irq_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_irq_o |-> $past(res_valid_i) && ($past(mode.cmp) == CMP_IRQ));
  a_r2_irq_pulse_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!res_valid_i || mode.cmp != CMP_IRQ) |=> !thr_irq_o);
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |-> !mag[DATA_W-1]);
  a_r5_irq_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_irq_o |-> mode.cmp[1]);
endmodule

// File: tb/adc_thresh_mon_test.sv
`timescale 1ns/1ps
module adc_thresh_mon_test;
  localparam int DW = 24;
  localparam int CW = 16;
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0]        MAXM = {1'b0, {(DW-1){1'b1}}};

  logic clk = 0, rst_n = 0;
  logic we = 0; logic [1:0] wa = 0; logic [31:0] wd = 0;
  logic v = 0; logic [DW-1:0] d = 0;
  logic thr_irq, cnt_irq, exc; logic [31:0] acc; logic [CW-1:0] cnt;

  always #2 clk = ~clk;

  adc_thresh_mon uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .res_valid_i(v), .res_data_i(d), .thr_irq_o(thr_irq), .cnt_irq_o(cnt_irq),
    .acc_exceed_o(exc), .acc_o(acc), .evt_cnt_o(cnt)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [1:0] m_cmp = 0, m_accm = 0;
  logic [DW-1:0] m_mth = 0; logic [CW-1:0] m_lim = 0; logic [31:0] m_ath = 0;
  logic [CW-1:0] m_cnt = 0; logic [31:0] m_acc = 0; logic m_irq = 0;

  function automatic logic [DW-1:0] f_mag(input logic signed [DW-1:0] x);
    if (x == MINV) return MAXM;
    return (x < 0) ? DW'(-x) : DW'(x);
  endfunction

  function automatic logic [31:0] f_sext(input logic signed [DW-1:0] x);
    return 32'(x);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string ctx);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (%s): actual %0h expected %0h", tag, ctx, act, exp);
    end
  endtask

  task automatic compare_all(input string ctx);
    chk(32'(thr_irq), 32'(m_irq), "R2", ctx);
    chk(32'(cnt), 32'(m_cnt), "R4", ctx);
    chk(32'(cnt_irq), 32'(m_cmp[1] && m_cnt >= m_lim), "R5", ctx);
    chk(acc, m_acc, "R6", ctx);
    chk(32'(exc), 32'($signed(m_acc) > $signed(m_ath)), "R8", ctx);
  endtask

  task automatic apply(input logic iwe, input logic [1:0] iwa, input logic [31:0] iwd,
                       input logic iv, input logic [DW-1:0] id, input string ctx);
    logic [DW-1:0] mg;
    logic [CW-1:0] n_cnt; logic [31:0] n_acc;
    @(negedge clk);
    we = iwe; wa = iwa; wd = iwd; v = iv; d = id;
    mg = f_mag(id);
    n_cnt = m_cnt; n_acc = m_acc;
    m_irq = iv && m_cmp == 2'b01 && mg > m_mth;
    if (iwe && iwa == 2'd0) begin
      n_cnt = 0; n_acc = 0;
    end else begin
      if (iv && ((m_cmp == 2'b10 && mg > m_mth) || (m_cmp == 2'b11 && mg < m_mth)) && m_cnt < m_lim)
        n_cnt = m_cnt + 1'b1;
      case (m_accm)
        2'b01: if (iv) n_acc = m_acc + f_sext(id);
        2'b10: if (iv) n_acc = m_acc - f_sext(id);
        2'b11: n_acc = 0;
        default: ;
      endcase
    end
    if (iwe) case (iwa)
      2'd0: begin m_cmp = iwd[1:0]; m_accm = iwd[3:2]; end
      2'd1: m_mth = iwd[DW-1:0];
      2'd2: m_lim = iwd[CW-1:0];
      default: m_ath = iwd;
    endcase
    m_cnt = n_cnt; m_acc = n_acc;
    @(posedge clk); #1;
    compare_all(ctx);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] dat, input string ctx);
    apply(1'b1, a, dat, 1'b0, '0, ctx);
  endtask

  task automatic smp(input logic [DW-1:0] x, input string ctx);
    apply(1'b0, 2'd0, 32'd0, 1'b1, x, ctx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    compare_all("R1 reset state");

    // R10 map; R2 irq mode, equal magnitude no pulse, negative input
    wr(2'd0, 32'h0000_0001, "R10 mode write");
    wr(2'd1, 32'd100, "R10 level");
    smp(DW'(100), "R2 equal");
    smp(DW'(-101), "R2 negative above");
    chk(32'(thr_irq), 32'd1, "R2", "pulse after -101");
    smp(DW'(5), "R2 below");
    chk(32'(thr_irq), 32'd0, "R2", "pulse is one cycle");

    // R3 saturation of most negative code
    wr(2'd1, 32'(MAXM - 1'b1), "R3 level max-1");
    smp(MINV, "R3 min fires");
    chk(32'(thr_irq), 32'd1, "R3", "min code above max-1");
    wr(2'd1, 32'(MAXM), "R3 level max");
    smp(MINV, "R3 min silent");
    chk(32'(thr_irq), 32'd0, "R3", "min code not above max");

    // R4/R5 counting above, limit 3
    wr(2'd1, 32'd50, "R4 level");
    wr(2'd2, 32'd3, "R5 limit");
    wr(2'd0, 32'h0000_0002, "R4 count-above mode");
    smp(DW'(50), "R4 equal not counted");
    for (int i = 0; i < 5; i++) smp(DW'(-60 - i), "R5 saturate count");
    chk(32'(cnt), 32'd3, "R5", "count stops at limit");
    chk(32'(cnt_irq), 32'd1, "R5", "limit flag");
    wr(2'd0, 32'h0000_0003, "R4 count-below mode");
    smp(DW'(-10), "R4 below counted");
    smp(DW'(70), "R4 above ignored");
    chk(32'(cnt), 32'd1, "R4", "below count");

    // R6 add/sub and wrap, R8 exceed
    wr(2'd3, 32'd1000, "R8 acc level");
    wr(2'd0, 32'h0000_0004, "R6 add mode");
    smp(DW'(999), "R8 at 999");
    chk(32'(exc), 32'd0, "R8", "999 not above 1000");
    smp(DW'(2), "R8 at 1001");
    chk(32'(exc), 32'd1, "R8", "1001 above 1000");
    for (int i = 0; i < 300; i++) smp(MAXM, "R6 wrap add");
    wr(2'd0, 32'h0000_0008, "R6 sub mode");
    for (int i = 0; i < 300; i++) smp(MINV, "R6 wrap sub");

    // R7 hold and zero
    wr(2'd0, 32'h0000_0004, "R7 add again");
    smp(DW'(77), "R7 load");
    apply(1'b0, 2'd0, 32'd0, 1'b0, DW'(5), "R7 no valid holds");
    chk(acc, 32'd77, "R7", "hold without valid");
    wr(2'd0, 32'h0000_000C, "R7 zero mode");
    smp(DW'(33), "R7 zero forced");
    chk(acc, 32'd0, "R7", "zero mode");

    // R9 collision: mode write with valid sample in same cycle
    wr(2'd0, 32'h0000_0006, "R9 setup");
    smp(DW'(-200), "R9 prime");
    apply(1'b1, 2'd0, 32'h0000_0006, 1'b1, DW'(300), "R9 collide");
    chk(acc, 32'd0, "R9", "sum cleared, sample dropped");
    chk(32'(cnt), 32'd0, "R9", "count cleared, sample dropped");

    // random phase
    for (int blk = 0; blk < 24; blk++) begin
      wr(2'd1, ($urandom % 4 == 0) ? 32'($urandom % 64) : 32'($urandom), "R10 rnd level");
      wr(2'd2, 32'($urandom % 40), "R10 rnd limit");
      wr(2'd3, $urandom, "R10 rnd acc level");
      wr(2'd0, 32'($urandom % 16), "R10 rnd mode");
      for (int k = 0; k < 250; k++) begin
        logic [DW-1:0] x;
        int sel = $urandom % 10;
        x = (sel == 0) ? MINV : (sel == 1) ? MAXM : (sel == 2) ? m_mth : DW'($urandom);
        if ($urandom % 40 == 0)
          apply(1'b1, 2'($urandom % 4), 32'($urandom % 16), 1'b1, x, "R9 rnd collide");
        else
          apply(1'b0, 2'd0, 32'd0, ($urandom % 4) != 0, x, "rnd stream");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule